// File: doc/BRIEF.md
# Shared-Converter Conversion Sequencer

This block decides when a single analog-to-digital converter, shared by many trigger sources, samples and converts, and which input channel it uses. Six conversion slots are each programmed with an input channel, the trigger line that starts them, and a sample-window length. A pulse on a trigger line marks every slot listening to that line as pending. Pending slots are then served one at a time. Each one gets a sample phase, then a conversion phase, and then a result strobe.

The analog converter is outside the block. The sequencer drives the channel number, a sample-phase level and a conversion-phase level. It waits for a one-cycle done pulse from the converter and then reports the finished slot and its channel. The sample window is timed in converter clocks, which a programmable prescaler derives from the system clock. One slot can be picked as the interrupt source. A continuous mode decides whether every completion pulses the interrupt, or only completions that find the interrupt flag clear.

Top module: `conv_sequencer`

## Requirements
- R1: Slot n (n = 0..5) is written at cfgAddr n. The channel is in cfgData[3:0], the trigger code in cfgData[12:8] and the acquisition value in cfgData[24:16]. The channel of a served slot appears on adcChan and on resChan.
- R2: cfgAddr 6 bits [3:0] hold the prescale value P. After a grant, adcSample is high for exactly (A+1)*(P+1) system cycles, where A is the slot's acquisition value. adcConvert then stays high until adcDone is seen. The two phases never overlap, and adcChan is steady during sampling.
- R3: Trigger code k matches trigIn[k]. Code 0 never matches. One pulse makes every slot with a matching code pending.
- R4: Pending slots are served in ascending slot order, starting above the last slot served and wrapping to the lowest pending slot.
- R5: The cycle after adcDone is seen in the conversion phase, resValid is high for one cycle, carrying resSlot and resChan of the finished slot.
- R6: A trigger for a slot that is already pending and not being granted sets that slot's bit of ovfFlag. The bit stays set until cfgAddr 7 is written with a 1 in cfgData[8+n].
- R7: cfgAddr 6 bits [10:8] select the interrupt slot, and bit 12 enables it. intPulse is only raised in the same cycle as the resValid of the selected slot. Other slots, and a disabled interrupt, never raise it.
- R8: cfgAddr 6 bit 13 selects continuous mode, in which every selected completion pulses. Otherwise a completion pulses only while intFlag is clear. intFlag is set on each selected completion and is cleared by writing cfgAddr 7 with cfgData[0] = 1.
- R9: After reset, adcSample, adcConvert, resValid, intPulse, intFlag and ovfFlag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Write strobe for the configuration port |
| cfgAddr | input | 3 | Register address: 0..5 slots, 6 global, 7 clear |
| cfgData | input | 32 | Write data |
| trigIn | input | 32 | Trigger pulses, one line per code |
| adcDone | input | 1 | Converter finished the current conversion |
| adcChan | output | 4 | Channel selected for the converter |
| adcSample | output | 1 | Sample phase active |
| adcConvert | output | 1 | Conversion phase active |
| resValid | output | 1 | End-of-conversion strobe |
| resSlot | output | 3 | Slot that finished |
| resChan | output | 4 | Channel of the slot that finished |
| intPulse | output | 1 | Interrupt pulse |
| intFlag | output | 1 | Sticky interrupt flag |
| ovfFlag | output | 6 | Sticky per-slot trigger overflow |

## Verification
The bench fires one trigger code at several slots and checks that all of them complete. A design that pends only the first match would lose completions. It re-triggers lower-numbered slots while a round is in flight. A design that always picks the lowest pending slot would finish slot 0 before slot 4 instead of wrapping to it. Sample lengths are measured against (A+1)*(P+1) for random prescale and acquisition values, which exposes an off-by-one in either counter. Interrupt counts are compared in both modes with the flag left set, so a design that ignores the flag, or ignores the continuous bit, shows up as an extra or missing pulse.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
  localparam int SEQ_SLOTS = 6;
  localparam int SEQ_IDX_W = $clog2(SEQ_SLOTS);
  localparam logic [2:0] ADDR_GLOBAL = 3'd6;
  localparam logic [2:0] ADDR_CLEAR  = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 grant;  // slot is taken into service
    logic                 eoc;    // current slot finished converting
    logic [SEQ_IDX_W-1:0] slot;   // granted slot on grant, current slot on eoc
  } seqStrobe_t;
endpackage

// File: rtl/convseq_dp.sv
module convseq_dp
  import convseq_pkg::*;
#(
  parameter int NUM_SLOTS = SEQ_SLOTS,
  parameter int CH_W      = 4,
  parameter int TRIG_W    = 5,
  parameter int ACQ_W     = 9,
  parameter int PRE_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgAddr,
  input  logic [DATA_W-1:0]    cfgData,
  input  logic [(1<<TRIG_W)-1:0] trigIn,
  input  seqStrobe_t           strobe,
  output logic [NUM_SLOTS-1:0] hitVec,
  output logic [ACQ_W-1:0]     curAcq,
  output logic [PRE_W-1:0]     preDiv,
  output logic [SEQ_IDX_W-1:0] intSel,
  output logic                 intEn,
  output logic                 contMode,
  output logic                 clrInt,
  output logic [NUM_SLOTS-1:0] clrOvf,
  output logic [CH_W-1:0]      adcChan,
  output logic                 resValid,
  output logic [SEQ_IDX_W-1:0] resSlot,
  output logic [CH_W-1:0]      resChan
);
  localparam int CH_LSB   = 0;
  localparam int TRIG_LSB = 8;
  localparam int ACQ_LSB  = 16;
  localparam int SEL_LSB  = 8;
  localparam int EN_BIT   = 12;
  localparam int CONT_BIT = 13;
  localparam int OVF_LSB  = 8;

  logic [CH_W-1:0]   chanCfg [NUM_SLOTS];
  logic [TRIG_W-1:0] trigCfg [NUM_SLOTS];
  logic [ACQ_W-1:0]  acqCfg  [NUM_SLOTS];
  logic [CH_W-1:0]   curChan;

  logic globalWr;
  assign globalWr = cfgWe && (cfgAddr == ADDR_GLOBAL);
  assign clrInt   = cfgWe && (cfgAddr == ADDR_CLEAR) && cfgData[0];
  assign clrOvf   = (cfgWe && (cfgAddr == ADDR_CLEAR)) ? cfgData[OVF_LSB +: NUM_SLOTS] : '0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic slotWr;
    assign slotWr = cfgWe && (cfgAddr == 3'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanCfg[i] <= '0;
        trigCfg[i] <= '0;
        acqCfg[i]  <= '0;
      end else if (slotWr) begin
        chanCfg[i] <= cfgData[CH_LSB +: CH_W];
        trigCfg[i] <= cfgData[TRIG_LSB +: TRIG_W];
        acqCfg[i]  <= cfgData[ACQ_LSB +: ACQ_W];
      end
    end
    // code zero is the "no trigger" setting
    assign hitVec[i] = (trigCfg[i] != '0) && trigIn[trigCfg[i]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preDiv   <= '0;
      intSel   <= '0;
      intEn    <= 1'b0;
      contMode <= 1'b0;
    end else if (globalWr) begin
      preDiv   <= cfgData[PRE_W-1:0];
      intSel   <= cfgData[SEL_LSB +: SEQ_IDX_W];
      intEn    <= cfgData[EN_BIT];
      contMode <= cfgData[CONT_BIT];
    end
  end

  // snapshot of the slot being served, so later writes do not disturb it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curChan <= '0;
      curAcq  <= '0;
    end else if (strobe.grant) begin
      curChan <= chanCfg[strobe.slot];
      curAcq  <= acqCfg[strobe.slot];
    end
  end
  assign adcChan = curChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resSlot  <= '0;
      resChan  <= '0;
    end else begin
      resValid <= strobe.eoc;
      if (strobe.eoc) begin
        resSlot <= strobe.slot;
        resChan <= curChan;
      end
    end
  end
endmodule

// File: rtl/convseq_ctrl.sv
module convseq_ctrl
  import convseq_pkg::*;
#(
  parameter int NUM_SLOTS = SEQ_SLOTS,
  parameter int ACQ_W     = 9,
  parameter int PRE_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] hitVec,
  input  logic [ACQ_W-1:0]     curAcq,
  input  logic [PRE_W-1:0]     preDiv,
  input  logic [SEQ_IDX_W-1:0] intSel,
  input  logic                 intEn,
  input  logic                 contMode,
  input  logic                 clrInt,
  input  logic [NUM_SLOTS-1:0] clrOvf,
  input  logic                 adcDone,
  output seqStrobe_t           strobe,
  output logic                 adcSample,
  output logic                 adcConvert,
  output logic                 intPulse,
  output logic                 intFlag,
  output logic [NUM_SLOTS-1:0] ovfFlag
);
  seqState_t            state;
  logic [NUM_SLOTS-1:0] pending;
  logic [SEQ_IDX_W-1:0] curSlot;
  logic [SEQ_IDX_W-1:0] lastSlot;
  logic [PRE_W-1:0]     preCnt;
  logic [ACQ_W-1:0]     acqCnt;

  function automatic logic [SEQ_IDX_W-1:0] lowestSet(input logic [NUM_SLOTS-1:0] v);
    logic [SEQ_IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (v[i]) r = SEQ_IDX_W'(i);
    return r;
  endfunction

  // slots numbered above the last one served belong to the current round
  logic [NUM_SLOTS-1:0] aboveMask;
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_above
    assign aboveMask[i] = (SEQ_IDX_W'(i) > lastSlot);
  end

  logic [NUM_SLOTS-1:0] roundPend;
  logic [SEQ_IDX_W-1:0] nextIdx;
  logic                 grant;
  logic [NUM_SLOTS-1:0] grantVec;
  logic                 eoc;
  logic                 tick;
  logic                 eocSel;

  assign roundPend = pending & aboveMask;
  assign nextIdx   = (|roundPend) ? lowestSet(roundPend) : lowestSet(pending);
  assign grant     = (state == ST_IDLE) && (|pending);
  assign grantVec  = grant ? (NUM_SLOTS'(1) << nextIdx) : '0;
  assign eoc       = (state == ST_CONV) && adcDone;
  assign tick      = (preCnt >= preDiv);
  assign eocSel    = eoc && intEn && (curSlot == intSel);

  assign strobe.grant = grant;
  assign strobe.eoc   = eoc;
  assign strobe.slot  = grant ? nextIdx : curSlot;

  assign adcSample  = (state == ST_SAMPLE);
  assign adcConvert = (state == ST_CONV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      ovfFlag <= '0;
    end else begin
      pending <= (pending & ~grantVec) | hitVec;
      ovfFlag <= (ovfFlag & ~clrOvf) | (hitVec & pending & ~grantVec);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curSlot  <= '0;
      lastSlot <= SEQ_IDX_W'(NUM_SLOTS - 1);
      preCnt   <= '0;
      acqCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (grant) begin
            state    <= ST_SAMPLE;
            curSlot  <= nextIdx;
            lastSlot <= nextIdx;
            preCnt   <= '0;
            acqCnt   <= '0;
          end
        end
        ST_SAMPLE: begin
          if (tick) begin
            preCnt <= '0;
            if (acqCnt == curAcq) state <= ST_CONV;
            else acqCnt <= acqCnt + 1'b1;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (adcDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intPulse <= 1'b0;
      intFlag  <= 1'b0;
    end else begin
      intPulse <= eocSel && (contMode || !intFlag);
      if (eocSel) intFlag <= 1'b1;
      else if (clrInt) intFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import convseq_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int TRIG_W = 5,
  parameter int ACQ_W  = 9,
  parameter int PRE_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgAddr,
  input  logic [31:0]            cfgData,
  input  logic [(1<<TRIG_W)-1:0] trigIn,
  input  logic                   adcDone,
  output logic [CH_W-1:0]        adcChan,
  output logic                   adcSample,
  output logic                   adcConvert,
  output logic                   resValid,
  output logic [SEQ_IDX_W-1:0]   resSlot,
  output logic [CH_W-1:0]        resChan,
  output logic                   intPulse,
  output logic                   intFlag,
  output logic [SEQ_SLOTS-1:0]   ovfFlag
);
  seqStrobe_t           strobe;
  logic [SEQ_SLOTS-1:0] hitVec;
  logic [ACQ_W-1:0]     curAcq;
  logic [PRE_W-1:0]     preDiv;
  logic [SEQ_IDX_W-1:0] intSel;
  logic                 intEn;
  logic                 contMode;
  logic                 clrInt;
  logic [SEQ_SLOTS-1:0] clrOvf;

  convseq_dp #(
    .NUM_SLOTS(SEQ_SLOTS), .CH_W(CH_W), .TRIG_W(TRIG_W),
    .ACQ_W(ACQ_W), .PRE_W(PRE_W), .DATA_W(32)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .trigIn(trigIn), .strobe(strobe), .hitVec(hitVec), .curAcq(curAcq),
    .preDiv(preDiv), .intSel(intSel), .intEn(intEn), .contMode(contMode),
    .clrInt(clrInt), .clrOvf(clrOvf), .adcChan(adcChan), .resValid(resValid),
    .resSlot(resSlot), .resChan(resChan)
  );

  convseq_ctrl #(
    .NUM_SLOTS(SEQ_SLOTS), .ACQ_W(ACQ_W), .PRE_W(PRE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hitVec(hitVec), .curAcq(curAcq), .preDiv(preDiv),
    .intSel(intSel), .intEn(intEn), .contMode(contMode), .clrInt(clrInt),
    .clrOvf(clrOvf), .adcDone(adcDone), .strobe(strobe), .adcSample(adcSample),
    .adcConvert(adcConvert), .intPulse(intPulse), .intFlag(intFlag), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/convseq_chk.sv
module convseq_chk
  import convseq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic [2:0]           cfgAddr,
  input logic [CH_W-1:0]      adcChan,
  input logic                 adcSample,
  input logic                 adcConvert,
  input logic                 resValid,
  input logic [SEQ_IDX_W-1:0] resSlot,
  input logic                 intPulse,
  input logic                 intFlag,
  input logic [SEQ_SLOTS-1:0] ovfFlag
);
  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(adcSample && adcConvert));
  // R2
  sample_to_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcSample) |-> adcConvert);
  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcSample && $past(adcSample)) |-> $stable(adcChan));
  // R5
  eoc_follows_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcConvert) |-> resValid);
  // R5
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  // R5
  eoc_slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resSlot < SEQ_IDX_W'(SEQ_SLOTS)));
  // R7
  int_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |-> resValid);
  // R8
  int_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |-> intFlag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intFlag) |-> $past(cfgWe && (cfgAddr == ADDR_CLEAR)));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(ovfFlag) & ~ovfFlag)) |-> $past(cfgWe && (cfgAddr == ADDR_CLEAR)));
endmodule

bind conv_sequencer convseq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .adcChan(adcChan),
  .adcSample(adcSample), .adcConvert(adcConvert), .resValid(resValid),
  .resSlot(resSlot), .intPulse(intPulse), .intFlag(intFlag), .ovfFlag(ovfFlag)
);

// File: tb/conv_sequencer_tb.sv
`timescale 1ns/1ps
module conv_sequencer_tb;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [31:0] trigIn = '0;
  logic        adcDone = 1'b0;
  logic [3:0]  adcChan;
  logic        adcSample, adcConvert, resValid, intPulse, intFlag;
  logic [2:0]  resSlot;
  logic [3:0]  resChan;
  logic [5:0]  ovfFlag;

  always #2 clk = ~clk;

  conv_sequencer u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .trigIn(trigIn), .adcDone(adcDone), .adcChan(adcChan), .adcSample(adcSample),
    .adcConvert(adcConvert), .resValid(resValid), .resSlot(resSlot), .resChan(resChan),
    .intPulse(intPulse), .intFlag(intFlag), .ovfFlag(ovfFlag)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench copy of programmed state
  int mChan[6], mTrig[6], mAcq[6];
  int mPre = 0, mSel = 0, mEn = 0, mCont = 0;
  int lastModel = 5;
  bit flagModel = 0;

  // observation log
  int evSlot[64], evChan[64], evLen[64], evSChan[64];
  int evCount = 0, intCount = 0, sampCnt = 0, lastLen = 0, lastSChan = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: done pulse LAT cycles into the conversion phase
  initial begin
    int convCnt = 0;
    forever begin
      @(negedge clk);
      if (adcConvert) begin
        convCnt++;
        adcDone = (convCnt == LAT);
      end else begin
        convCnt = 0;
        adcDone = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (adcSample) begin
      sampCnt++;
      lastSChan = int'(adcChan);
    end else if (sampCnt != 0) begin
      lastLen = sampCnt;
      sampCnt = 0;
    end
    if (resValid && evCount < 64) begin
      evSlot[evCount]  = int'(resSlot);
      evChan[evCount]  = int'(resChan);
      evLen[evCount]   = lastLen;
      evSChan[evCount] = lastSChan;
      evCount++;
    end
    if (intPulse) intCount++;
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(addr); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setSlot(input int s, input int ch, input int tr, input int acq);
    mChan[s] = ch; mTrig[s] = tr; mAcq[s] = acq;
    wr(s, 32'(ch) | (32'(tr) << 8) | (32'(acq) << 16));
  endtask

  task automatic setGlobal(input int pre, input int sel, input int en, input int cont);
    mPre = pre; mSel = sel; mEn = en; mCont = cont;
    wr(6, 32'(pre) | (32'(sel) << 8) | (32'(en) << 12) | (32'(cont) << 13));
  endtask

  task automatic clearInt();
    wr(7, 32'h1);
    flagModel = 0;
  endtask

  task automatic fire(input logic [31:0] v);
    @(negedge clk);
    trigIn = v;
    @(negedge clk);
    trigIn = '0;
  endtask

  function automatic int sampleLen(input int s);
    return (mAcq[s] + 1) * (mPre + 1);
  endfunction

  function automatic bit slotHit(input int s, input logic [31:0] v);
    return (mTrig[s] != 0) && v[mTrig[s]];
  endfunction

  task automatic waitEvents(input int n);
    for (int w = 0; w < 20000 && evCount < n; w++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // compare one logged event against the expected slot
  task automatic checkEvent(input int i, input int s);
    check(evSlot[i] == s, "R4 service order", evSlot[i], s);
    check(evChan[i] == mChan[s], "R1/R5 result channel", evChan[i], mChan[s]);
    check(evSChan[i] == mChan[s], "R1 adcChan while sampling", evSChan[i], mChan[s]);
    check(evLen[i] == sampleLen(s), "R2 sample window length", evLen[i], sampleLen(s));
  endtask

  // fire from idle, predict the order and interrupt count, then compare
  task automatic runRound(input logic [31:0] v);
    int exp[6];
    int n = 0, cur = lastModel, selHit = 0, expPulses;
    bit [5:0] mask = '0;
    for (int s = 0; s < 6; s++) if (slotHit(s, v)) mask[s] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cur = (cur == 5) ? 0 : cur + 1;
      if (mask[cur]) begin
        exp[n] = cur; n++;
        if (mEn != 0 && cur == mSel) selHit = 1;
      end
    end
    evCount = 0; intCount = 0;
    fire(v);
    if (n == 0) repeat (40) @(negedge clk);
    else waitEvents(n);
    check(evCount == n, "R3 completions per trigger", evCount, n);
    for (int i = 0; i < n && i < evCount; i++) checkEvent(i, exp[i]);
    if (n > 0) lastModel = exp[n-1];
    expPulses = (selHit != 0 && (mCont != 0 || !flagModel)) ? 1 : 0;
    check(intCount == expPulses, "R7/R8 interrupt pulses", intCount, expPulses);
    if (selHit != 0) flagModel = 1;
    check(intFlag == flagModel, "R8 interrupt flag", int'(intFlag), int'(flagModel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!adcSample && !adcConvert, "R9 phases idle", int'({adcSample, adcConvert}), 0);
    check(!resValid && !intPulse, "R9 strobes low", int'({resValid, intPulse}), 0);
    check(!intFlag && ovfFlag == 0, "R9 flags clear", int'({intFlag, ovfFlag}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // three slots share code 5; interrupt on slot 5, non-continuous (R3, R7)
    setSlot(0, 1, 15, 19);
    setSlot(1, 3, 17, 4);
    setSlot(2, 5, 9, 2);
    setSlot(3, 0, 5, 19);
    setSlot(4, 2, 5, 3);
    setSlot(5, 4, 5, 0);
    setGlobal(1, 5, 1, 0);
    runRound(32'(1) << 5);
    // R8 flag left set: no new pulse in non-continuous mode
    runRound(32'(1) << 5);
    // R8 continuous mode pulses even with flag set
    setGlobal(3, 5, 1, 1);
    runRound(32'(1) << 5);
    clearInt();
    check(intFlag == 1'b0, "R8 flag clear by write", int'(intFlag), 0);
    // R7 non-selected slots do not pulse
    runRound((32'(1) << 15) | (32'(1) << 9));
    // R3 code zero never matches
    setSlot(2, 7, 0, 1);
    runRound(32'h1);

    // R4 wrap within round and R6 overflow
    setGlobal(0, 0, 0, 0);
    for (int s = 0; s < 6; s++) setSlot(s, 8 + s, 20 + s, 6);
    lastModel = 5;
    begin
      int expOrd[4] = '{1, 3, 4, 0};
      bit [5:0] ovfSeen;
      evCount = 0;
      // drain earlier rounds so that the last served slot is known
      fire((32'(1) << 25));
      waitEvents(1);
      evCount = 0;
      fire((32'(1) << 21) | (32'(1) << 23));
      for (int w = 0; w < 200 && !adcSample; w++) @(negedge clk);
      fire((32'(1) << 20) | (32'(1) << 24) | (32'(1) << 23));
      @(negedge clk);
      ovfSeen = ovfFlag;
      check(ovfSeen == 6'b001000, "R6 overflow on pending slot", int'(ovfSeen), 8);
      waitEvents(4);
      check(evCount == 4, "R4 completions", evCount, 4);
      for (int i = 0; i < 4 && i < evCount; i++) checkEvent(i, expOrd[i]);
      check(ovfFlag == 6'b001000, "R6 overflow sticky", int'(ovfFlag), 8);
      wr(7, 32'h0000_0100);
      check(ovfFlag == 6'b001000, "R6 other bits unaffected", int'(ovfFlag), 8);
      wr(7, 32'h0000_0800);
      check(ovfFlag == 6'b000000, "R6 overflow cleared", int'(ovfFlag), 0);
      lastModel = 0;
    end

    // random rounds
    for (int r = 0; r < 40; r++) begin
      for (int s = 0; s < 6; s++)
        setSlot(s, int'($urandom_range(15, 0)), int'($urandom_range(4, 1)), int'($urandom_range(7, 0)));
      setGlobal(int'($urandom_range(3, 0)), int'($urandom_range(6, 0)),
                int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
      if ($urandom_range(1, 0) == 1) clearInt();
      runRound(32'($urandom_range(15, 0)) << 1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule